// File: doc/BRIEF.md
# Cartridge Window SRAM Bank Controller

This block sits on the cartridge slot of an 8-bit home computer and lets a fixed 8 KB CPU window, pages $80 to $9F, reach any of sixteen 8 KB banks of an external SRAM. Software selects a bank by writing a byte anywhere in the cartridge control page ($D5xx). The low nibble of that byte is the bank number. It is taken while the bus clock is high and takes effect on the falling edge of the bus clock. The bank number drives the four upper SRAM address lines at all times.

The block also produces the active-low SRAM write strobe for writes into the window. SRAM chip select, the lower address lines and the SRAM data lines connect straight to the bus and do not pass through this block. The block samples the slow bus signals with a fast local clock `clk`. The bus clock and all bus strobes are inputs that `clk` observes. The block has no valid/ready interface: each bus cycle is a fixed-timing strobe, and the block has no means to stall the processor.

Top module: `cwb_bank_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the bank is 0. `sram_addr_hi` reads 0 and `sram_we_n` is high while no window write is in progress.
- R2: A control-page write does not change `sram_addr_hi` while the bus clock is still high. The new bank appears on `sram_addr_hi` one `clk` cycle after the first `clk` edge that sees `bus_clk` low following a high phase.
- R3: The committed bank equals `bus_data[3:0]`. Bits 7..4 of `bus_data` have no effect on `sram_addr_hi`. Bank 15 (data 8'hFF) is reachable.
- R4: A control-page access with `bus_rd_wr` high (read) leaves the bank unchanged.
- R5: Control-page select and write strobes present only while `bus_clk` is low load nothing.
- R6: `sram_we_n` is low exactly when `win_sel_n` is low, `bus_rd_wr` is low and `bus_clk` is high. Control-page writes never assert it.
- R7: `sram_addr_hi` holds the bank through window reads, window writes and both bus phases. It changes only at a commit.
- R8: If `bus_data` changes during the high phase of a control write, the value present at the last `clk` edge before the bus clock falls is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset, clears the bank to 0 |
| win_sel_n | input | 1 | Active-low window select, low for pages $80-$9F |
| ctl_sel_n | input | 1 | Active-low control-page select, low for page $D5 |
| bus_rd_wr | input | 1 | High for a read, low for a write |
| bus_clk | input | 1 | Processor bus clock; high is the data phase |
| bus_data | input | 8 | Processor data bus |
| sram_addr_hi | output | 4 | Upper SRAM address bits, the selected bank |
| sram_we_n | output | 1 | Active-low SRAM write enable |

## Verification
The hardest case to produce is a control write whose data changes part-way through the high phase. The commit must use the last value seen before the fall, not the first. The stimulus splits one high phase into two parts with different data bytes. It also raises the control strobes while the bus clock is low and drops them before the clock rises. A behavioural model runs every `clk` cycle next to the design and tracks the pending and committed bank, so a commit that comes one cycle early or late is reported.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int CWB_DATA_W = 8;
  localparam int CWB_BANK_W = 4;

  typedef struct packed {
    logic win;
    logic ctl;
    logic wr;
    logic phi;
  } cwb_strobe_t;

  function automatic cwb_strobe_t cwb_decode(input logic win_n, input logic ctl_n,
                                             input logic rd_wr, input logic phi);
    cwb_strobe_t s;
    s.win = ~win_n;
    s.ctl = ~ctl_n;
    s.wr  = ~rd_wr;
    s.phi = phi;
    return s;
  endfunction
endpackage

// File: rtl/cwb_phase_det.sv
module cwb_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic phi,
  output logic phi_fall
);
  logic phi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phi_q <= 1'b0;
    else        phi_q <= phi;
  end

  assign phi_fall = phi_q & ~phi;

  // R2: a detected fall is always preceded by a sampled high phase
  a_r2_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    phi_fall |-> $past(phi));
endmodule

// File: rtl/cwb_bank_reg.sv
module cwb_bank_reg #(
  parameter int DATA_W   = cwb_pkg::CWB_DATA_W,
  parameter int BANK_W   = cwb_pkg::CWB_BANK_W,
  parameter int BANK_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cwb_pkg::cwb_strobe_t st,
  input  logic              phi_fall,
  input  logic [DATA_W-1:0] data,
  output logic [BANK_W-1:0] bank
);
  localparam int TOP_BIT = BANK_LSB + BANK_W - 1;

  logic [BANK_W-1:0] pend_q, pick;
  logic              pend_v;
  logic              take;

  generate
    for (genvar i = 0; i < BANK_W; i++) begin : g_pick
      assign pick[i] = data[BANK_LSB + i];
    end
  endgenerate

  assign take = st.phi & st.ctl & st.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pend_v <= 1'b0;
      bank   <= '0;
    end else begin
      if (take) begin
        pend_q <= pick;
        pend_v <= 1'b1;
      end else if (phi_fall) begin
        pend_v <= 1'b0;
      end
      if (phi_fall && pend_v) bank <= pend_q;
    end
  end

  // R7: the bank moves only in the cycle after a fall with a pending load
  a_r7_bank_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (bank != $past(bank)) |-> $past(phi_fall && pend_v));
  // R3: the committed value is the one captured from the data bus
  a_r3_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_fall && pend_v) |=> (bank == $past(pend_q)));
  // R5: nothing is captured while the bus clock is low
  a_r5_no_capture_low: assert property (@(posedge clk) disable iff (!rst_n)
    !st.phi |=> $stable(pend_q));
  // R4: a read in the control page never arms a load
  a_r4_read_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_v && (!st.wr || !st.ctl)) |=> !pend_v);

  initial begin
    if (TOP_BIT >= DATA_W) $display("cwb_bank_reg: bank field exceeds data bus");
  end
endmodule

// File: rtl/cwb_we_gen.sv
module cwb_we_gen (
  input  logic              clk,
  input  logic              rst_n,
  input  cwb_pkg::cwb_strobe_t st,
  output logic              we_n
);
  assign we_n = ~(st.win & st.wr & st.phi);

  // R6: the strobe needs the window, a write and the high phase
  a_r6_we_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (st.win && st.wr && st.phi));
  // R6: a control-page-only access never strobes the SRAM
  a_r6_ctl_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ctl && !st.win) |-> we_n);
endmodule

// File: rtl/cwb_bank_ctrl.sv
module cwb_bank_ctrl #(
  parameter int DATA_W   = cwb_pkg::CWB_DATA_W,
  parameter int BANK_W   = cwb_pkg::CWB_BANK_W,
  parameter int BANK_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_sel_n,
  input  logic              ctl_sel_n,
  input  logic              bus_rd_wr,
  input  logic              bus_clk,
  input  logic [DATA_W-1:0] bus_data,
  output logic [BANK_W-1:0] sram_addr_hi,
  output logic              sram_we_n
);
  cwb_pkg::cwb_strobe_t st;
  logic                 phi_fall;

  assign st = cwb_pkg::cwb_decode(win_sel_n, ctl_sel_n, bus_rd_wr, bus_clk);

  cwb_phase_det u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi      (bus_clk),
    .phi_fall (phi_fall)
  );

  cwb_bank_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .phi_fall (phi_fall),
    .data     (bus_data),
    .bank     (sram_addr_hi)
  );

  cwb_we_gen u_we (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (st),
    .we_n  (sram_we_n)
  );

  // R7: the address holds steady whenever the bus clock stays high
  a_r7_hold_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_clk) && bus_clk) |=> $stable(sram_addr_hi));
endmodule

// File: tb/cwb_bank_ctrl_bench.sv
module cwb_bank_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_sel_n = 1'b1, ctl_sel_n = 1'b1, bus_rd_wr = 1'b1, bus_clk = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic [3:0] sram_addr_hi;
  logic       sram_we_n;

  int checks = 0, errors = 0;
  int m_bank = 0, m_pend = 0, m_pv = 0, m_phi = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cwb_bank_ctrl u_cwb_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .win_sel_n(win_sel_n), .ctl_sel_n(ctl_sel_n),
    .bus_rd_wr(bus_rd_wr), .bus_clk(bus_clk), .bus_data(bus_data),
    .sram_addr_hi(sram_addr_hi), .sram_we_n(sram_we_n));

  // behavioural reference: pending nibble while high, commit when the clock is seen low
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_pend = 0; m_pv = 0; m_phi = 0;
    end else begin
      if (m_phi == 1 && bus_clk == 0 && m_pv == 1) m_bank = m_pend;
      if (bus_clk && !ctl_sel_n && !bus_rd_wr) begin
        m_pend = bus_data % 16; m_pv = 1;
      end else if (m_phi == 1 && bus_clk == 0) m_pv = 0;
      m_phi = bus_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R6 strobe, R7 address)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7", sram_addr_hi, m_bank);
      chk("R6", sram_we_n, (!win_sel_n && !bus_rd_wr && bus_clk) ? 0 : 1);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic setup(input logic w, input logic c, input logic rw, input logic [7:0] d);
    win_sel_n = w; ctl_sel_n = c; bus_rd_wr = rw; bus_data = d;
  endtask

  task automatic idle();
    setup(1'b1, 1'b1, 1'b1, 8'h00);
  endtask

  // one bus cycle: low setup, high phase with d1 then d2, then low again
  task automatic cyc(input logic w, input logic c, input logic rw,
                     input logic [7:0] d1, input logic [7:0] d2);
    setup(w, c, rw, d1); ticks(2);
    bus_clk = 1'b1; ticks(2);
    bus_data = d2; ticks(2);
    bus_clk = 1'b0; ticks(1);
    idle(); ticks(2);
  endtask

  initial begin
    #2000000;
    chk("WATCHDOG", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ticks(3);
    @(negedge clk);
    chk("R1", sram_addr_hi, 0);
    chk("R1", sram_we_n, 1);
    rst_n = 1'b1;
    ticks(2);
    @(negedge clk);
    chk("R1", sram_addr_hi, 0);

    // R2: no change during the high phase, change one cycle after the fall is seen
    setup(1'b1, 1'b0, 1'b0, 8'hA5); ticks(2);
    bus_clk = 1'b1; ticks(4);
    @(negedge clk); chk("R2", sram_addr_hi, 0);
    @(posedge clk); #1 bus_clk = 1'b0;
    @(negedge clk); chk("R2", sram_addr_hi, 0);
    @(negedge clk); chk("R3", sram_addr_hi, 5);
    idle(); ticks(2);

    // R4: control-page read
    cyc(1'b1, 1'b0, 1'b1, 8'h07, 8'h07);
    @(negedge clk); chk("R4", sram_addr_hi, 5);

    // R5: strobes only while the clock is low, then an empty high phase
    setup(1'b1, 1'b0, 1'b0, 8'h03); ticks(4);
    idle(); bus_clk = 1'b1; ticks(3); bus_clk = 1'b0; ticks(3);
    @(negedge clk); chk("R5", sram_addr_hi, 5);

    // R8: data changes mid high phase
    cyc(1'b1, 1'b0, 1'b0, 8'h02, 8'h0C);
    @(negedge clk); chk("R8", sram_addr_hi, 12);

    // R6: window write strobes during high phase only
    setup(1'b0, 1'b1, 1'b0, 8'h55); ticks(2);
    @(negedge clk); chk("R6", sram_we_n, 1);
    bus_clk = 1'b1; ticks(2);
    @(negedge clk); chk("R6", sram_we_n, 0);
    chk("R7", sram_addr_hi, 12);
    bus_clk = 1'b0; ticks(1);
    @(negedge clk); chk("R6", sram_we_n, 1);
    idle(); ticks(2);

    // R6: window read and control write never strobe
    setup(1'b0, 1'b1, 1'b1, 8'h00); bus_clk = 1'b1; ticks(2);
    @(negedge clk); chk("R6", sram_we_n, 1);
    bus_clk = 1'b0; idle(); ticks(2);
    setup(1'b1, 1'b0, 1'b0, 8'hFF); ticks(1); bus_clk = 1'b1; ticks(2);
    @(negedge clk); chk("R6", sram_we_n, 1);
    bus_clk = 1'b0; ticks(1); idle(); ticks(2);
    @(negedge clk); chk("R3", sram_addr_hi, 15);

    // R3: upper data bits ignored
    cyc(1'b1, 1'b0, 1'b0, 8'hF0, 8'hF0);
    @(negedge clk); chk("R3", sram_addr_hi, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h39, 8'h39);
    @(negedge clk); chk("R3", sram_addr_hi, 9);

    // R1: reset mid-use clears the bank
    rst_n = 1'b0; ticks(2);
    @(negedge clk); chk("R1", sram_addr_hi, 0);
    rst_n = 1'b1; ticks(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule